// File: doc/BRIEF.md
# Raster Timing Generator with Line Interrupt

This block produces the scan timing for a 640x480 progressive raster. It keeps a horizontal pixel counter and a vertical line counter that step on a pixel-clock enable. From those counters it derives active-low horizontal and vertical sync pulses and an active-video flag. Each line holds 800 pixel clocks: the visible pixels come first, then the front porch, the sync pulse and the back porch. Each frame holds 525 lines: the visible lines come first, and the vertical front porch, sync and back porch follow the last visible line.

The block has two interrupt sources. The raster-line source fires when the visible part of a chosen line has just ended, on the first front-porch pixel, so the handler has the whole horizontal blanking interval for its work. The vertical-blank source fires when the first non-visible line begins.

A small register port sets the target line and the per-source enables, and reads back the status. Status bits are cleared by writing a 1 to them. The interrupt request output is the OR of all status bits whose enable is set.

Top module: `raster_line_irq`

## Requirements
- R1: The x counter advances by one on each clock with `pix_en` high, wraps from H_TOTAL-1 (799) to 0, and x and y both hold while `pix_en` is low.
- R2: The y counter advances by one when x wraps, and wraps from V_TOTAL-1 (524) to 0.
- R3: `hsync_n` is low exactly while x is in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC), which is [656, 752), and high at all other times.
- R4: `vsync_n` is low exactly while y is in [V_ACTIVE+V_FP, V_ACTIVE+V_FP+V_SYNC), which is [490, 492), and high at all other times.
- R5: `active` is high exactly when x < 640 and y < 480.
- R6: The line status (bit 1 of the status register) is set on the pixel step that moves x from H_ACTIVE-1 to H_ACTIVE while y equals the target register.
- R7: A target value of V_ACTIVE (480) or more never sets the line status.
- R8: The vertical-blank status (bit 0 of the status register) is set on the pixel step that moves the counters to x=0, y=V_ACTIVE.
- R9: `irq` is high exactly when (status & enable) is non-zero. Enable bit 1 masks the line source and enable bit 0 masks the vertical-blank source, so a cleared enable bit keeps its source off `irq`.
- R10: A write to address 2 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0. When a status bit is set and cleared in the same cycle, the set wins.
- R11: A synchronous `rst` sets x, y, the status, the target and the enables to zero.
- R12: `reg_rdata` is combinational on `reg_addr`: address 0 gives the 10-bit target, address 1 gives the enables in bits 1:0, address 2 gives the status in bits 1:0, and address 3 reads as zero. Writes to address 0 and address 1 take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 target, 1 enable, 2 status |
| reg_wdata | input | TGT_W (10) | Register write data |
| reg_rdata | output | TGT_W (10) | Register read data, combinational on `reg_addr` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Active-video flag |
| x | output | XW (10) | Current pixel within the line |
| y | output | YW (10) | Current line within the frame |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value shows up on `x` and `y` in the same cycle. Within one line it also moves the edges of `hsync_n` and `active`, and within one frame it moves the edges of `vsync_n`. A wrong comparison in the interrupt logic shows as a status bit that rises one pixel step early or late, or on the wrong line. Because the status register is read back on every bench cycle and `irq` is compared on every cycle, such an error is caught on the first cycle it appears. The bench uses a scaled-down raster small enough that several complete frames, with both regular and gapped pixel enables, are compared cycle by cycle against an arithmetic model.

// File: rtl/raster_line_irq.sv
module raster_line_irq #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int TGT_W    = 10,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int XW      = $clog2(H_TOTAL),
  localparam int YW      = $clog2(V_TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [TGT_W-1:0] reg_wdata,
  output logic [TGT_W-1:0] reg_rdata,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             active,
  output logic [XW-1:0]    x,
  output logic [YW-1:0]    y,
  output logic             irq
);
  localparam int HS_LO = H_ACTIVE + H_FP;
  localparam int HS_HI = HS_LO + H_SYNC;
  localparam int VS_LO = V_ACTIVE + V_FP;
  localparam int VS_HI = VS_LO + V_SYNC;

  logic [XW-1:0]    xc;
  logic [YW-1:0]    yc;
  logic [TGT_W-1:0] tgt;
  logic [1:0]       en;
  logic [1:0]       st;
  logic [1:0]       clr;
  logic             x_last, y_last, line_hit, vb_hit;

  assign x_last   = xc == XW'(H_TOTAL - 1);
  assign y_last   = yc == YW'(V_TOTAL - 1);
  assign line_hit = pix_en && xc == XW'(H_ACTIVE - 1) && TGT_W'(yc) == tgt
                    && tgt < TGT_W'(V_ACTIVE);
  assign vb_hit   = pix_en && x_last && yc == YW'(V_ACTIVE - 1);
  assign clr      = (reg_wr && reg_addr == 2'd2) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      xc <= '0;
      yc <= '0;
    end else if (pix_en) begin
      xc <= x_last ? '0 : xc + 1'b1;
      if (x_last) yc <= y_last ? '0 : yc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt <= '0;
      en  <= '0;
      st  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) tgt <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) en <= reg_wdata[1:0];
      st <= (st & ~clr) | {line_hit, vb_hit};
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = tgt;
      2'd1:    reg_rdata = TGT_W'(en);
      2'd2:    reg_rdata = TGT_W'(st);
      default: reg_rdata = '0;
    endcase
  end

  assign hsync_n = !(xc >= XW'(HS_LO) && xc < XW'(HS_HI));
  assign vsync_n = !(yc >= YW'(VS_LO) && yc < YW'(VS_HI));
  assign active  = xc < XW'(H_ACTIVE) && yc < YW'(V_ACTIVE);
  assign x       = xc;
  assign y       = yc;
  assign irq     = |(st & en);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(xc) && $stable(yc)));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !x_last) |=> (xc == $past(xc) + 1'b1 && $stable(yc)));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (pix_en && x_last) |=> (xc == '0 && (yc == $past(yc) + 1'b1 || yc == '0)));
  assert_hsync_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> xc == XW'(HS_LO));
  assert_line_pos_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(st[1]) |-> (xc == XW'(H_ACTIVE) && TGT_W'(yc) == $past(tgt)));
  assert_line_range_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(st[1]) |-> $past(tgt) < TGT_W'(V_ACTIVE));
  assert_vb_pos_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(st[0]) |-> (xc == '0 && yc == YW'(V_ACTIVE)));
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (xc == '0 && yc == '0 && st == 2'b00 && en == 2'b00));
endmodule

// File: tb/raster_line_irq_bench.sv
module raster_line_irq_bench;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 6, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FR = HT * VT;

  logic clk = 0, rst = 1, pix_en = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [9:0] reg_wdata = 0, reg_rdata;
  logic hsync_n, vsync_n, active, irq;
  logic [3:0] x, y;

  int tests = 0, fails = 0;
  int ex = 0, ey = 0, etgt = 0, een = 0, est = 0;
  bit done = 0;

  always #5 clk = ~clk;

  raster_line_irq #(.H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) u_raster_line_irq (
    .clk(clk), .rst(rst), .pix_en(pix_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .active(active), .x(x), .y(y), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, ex, ey);
    end
  endtask

  task automatic compare_all();
    int rd;
    chk(int'(x) == ex, "R1 x", int'(x), ex);
    chk(int'(y) == ey, "R2 y", int'(y), ey);
    chk(hsync_n == !(ex >= HA + HF && ex < HA + HF + HS), "R3 hsync_n",
        int'(hsync_n), int'(!(ex >= HA + HF && ex < HA + HF + HS)));
    chk(vsync_n == !(ey >= VA + VF && ey < VA + VF + VS), "R4 vsync_n",
        int'(vsync_n), int'(!(ey >= VA + VF && ey < VA + VF + VS)));
    chk(active == (ex < HA && ey < VA), "R5 active", int'(active), int'(ex < HA && ey < VA));
    chk(irq == ((est & een) != 0), "R9 irq", int'(irq), int'((est & een) != 0));
    case (reg_addr)
      2'd0: rd = etgt;
      2'd1: rd = een;
      2'd2: rd = est;
      default: rd = 0;
    endcase
    chk(int'(reg_rdata) == rd, "R6/R8/R10/R12 rdata", int'(reg_rdata), rd);
  endtask

  task automatic tick(input bit pen, input bit wr, input logic [1:0] addr, input int wd);
    bit lh, vh;
    int c;
    @(negedge clk);
    rst = 0; pix_en = pen; reg_wr = wr; reg_addr = addr; reg_wdata = 10'(wd);
    @(posedge clk);
    lh = pen && ex == HA - 1 && ey == etgt && etgt < VA;
    vh = pen && ex == HT - 1 && ey == VA - 1;
    c  = (wr && addr == 2) ? (wd & 3) : 0;
    est = (est & ~c & 3) | (lh ? 2 : 0) | (vh ? 1 : 0);
    if (wr && addr == 0) etgt = wd;
    if (wr && addr == 1) een = wd & 3;
    if (pen) begin
      if (ex == HT - 1) begin
        ex = 0;
        ey = (ey == VT - 1) ? 0 : ey + 1;
      end else ex++;
    end
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; reg_wr = 0; pix_en = 1;
    @(posedge clk);
    ex = 0; ey = 0; etgt = 0; een = 0; est = 0;
    #1;
    chk(x == 0 && y == 0, "R11 counters", int'(x) + int'(y), 0);
    chk(irq == 0 && hsync_n && vsync_n && active, "R11 outputs", int'(irq), 0);
    reg_addr = 2;
    #1;
    chk(reg_rdata == 0, "R11 status", int'(reg_rdata), 0);
    reg_addr = 0;
    #1;
    chk(reg_rdata == 0, "R11 target", int'(reg_rdata), 0);
  endtask

  task automatic run(input int n, input int pmode);
    for (int i = 0; i < n; i++) begin
      bit pen = (pmode == 0) ? 1'b1 : (i % 3 != 0);
      if (i % 37 == 5) tick(pen, 1, 2, 3);
      else if (i % 53 == 7) tick(pen, 1, 2, 0);
      else tick(pen, 0, (pmode == 1 && i % 4 == 0) ? 2'(i % 3) : 2'd2, 0);
    end
  endtask

  initial begin
    do_reset();
    do_reset();
    tick(0, 1, 0, 2);
    tick(0, 1, 1, 3);
    tick(0, 0, 0, 0);
    chk(reg_rdata == 2, "R12 target readback", int'(reg_rdata), 2);
    tick(0, 0, 1, 0);
    chk(reg_rdata == 3, "R12 enable readback", int'(reg_rdata), 3);
    run(2 * FR, 0);
    run(3 * FR, 1);
    tick(0, 1, 0, 4);
    for (int i = 0; i < FR; i++) begin
      if (ex == HA - 1 && ey == etgt) tick(1, 1, 2, 2);
      else tick(1, 0, 2, 0);
    end
    chk((est & 2) != 0, "R10 set wins over clear", est, 2);
    chk(reg_rdata[1] == 1'b1, "R10 set wins readback", int'(reg_rdata[1]), 1);
    tick(0, 1, 1, 1);
    tick(0, 1, 2, 3);
    for (int i = 0; i < FR; i++) tick(1, 0, 2, 0);
    chk(reg_rdata[1] == 1'b1, "R6 line status set while masked", int'(reg_rdata[1]), 1);
    tick(0, 1, 2, 1);
    chk(irq == 0, "R9 masked line source", int'(irq), 0);
    tick(0, 1, 1, 2);
    tick(0, 1, 0, VA);
    tick(0, 1, 2, 3);
    for (int i = 0; i < FR; i++) tick(1, 0, 2, 0);
    chk(reg_rdata[1] == 1'b0, "R7 target equal to visible count", int'(reg_rdata[1]), 0);
    tick(0, 1, 0, VT - 2);
    for (int i = 0; i < FR; i++) tick(1, 0, 2, 0);
    chk(reg_rdata[1] == 1'b0, "R7 target in blanking", int'(reg_rdata[1]), 0);
    chk(reg_rdata[0] == 1'b1, "R8 vblank status", int'(reg_rdata[0]), 1);
    tick(0, 1, 0, 1);
    for (int i = 0; i < 40; i++) tick(1, 0, 2, 0);
    do_reset();
    for (int i = 0; i < 20; i++) tick(1, 0, 2, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule